// File: doc/BRIEF.md
# Two-Slot Video/Audio/Data Frame Codec

This block packs four 8-bit video channels, four single-bit serial audio lines and two single-bit asynchronous data lines into a stream of 22-bit words for a downstream serializer. It also unpacks the same stream on the far side. Transmit words come in two kinds that strictly alternate. The first kind carries video channels 1 and 2 plus every audio line. The second kind carries video channels 3 and 4 plus both data lines. A 2-bit tag at the top of each word says which kind it is.

On the transmit side, all inputs are sampled once per frame, when the first-kind word is built. The second-kind word reuses that same sample, so both halves of a frame describe the same instant. A video channel whose activity flag is low is sent as zeros. On the receive side, the tag steers the payload into per-channel holding registers. Each data line is cleaned by a three-sample majority vote. Words with an unknown tag are dropped and flagged. A lock indicator follows whether the tags alternate properly.

Both word ports use a valid/ready handshake, so a serializer clock enable can pace them. Transmit word bits: [21:20] tag, [19:12] first video field, [11:4] second video field, [3:0] side bits. Video channel k (k = 1..4) enters on vidIn[8k-1:8k-8] and leaves on vidOut[8k-1:8k-8]. Audio line k uses bit k-1 and data line k uses bit k-1.

Top module: `tdmFrameCodec`

## Requirements
- R1: The first word offered after reset carries tag 2'b11 (first kind). Each accepted word is followed by a word of the other kind, so tags 2'b11 and 2'b00 alternate. No other tag is ever sent.
- R2: A first-kind word is {2'b11, video1, video2, audio[3:0]}, with audio line 1 in bit 0.
- R3: A second-kind word is {2'b00, video3, video4, 2'b00, data[1:0]}, with data line 1 in bit 0.
- R4: All inputs are sampled at the clock edge that loads a first-kind word. The following second-kind word carries video 3/4 and data from that same sample, even if the inputs have changed since.
- R5: A video channel whose vidActive bit is 0 is sent as 8'h00.
- R6: While txValid is 1 and txReady is 0, txWord holds its value and txValid stays 1.
- R7: An accepted receive word with tag 2'b11 updates video 1/2 and audOut from its fields one cycle later. It leaves video 3/4 and datOut unchanged.
- R8: An accepted receive word with tag 2'b00 updates video 3/4 from bits [19:4] one cycle later. It leaves video 1/2 and audOut unchanged. Bits [1:0] feed the data filters.
- R9: Each data output is, one cycle after a tag-2'b00 word, the majority of that word's bit and the line's two previous tag-2'b00 samples. Missing history counts as 0.
- R10: An accepted word with tag 2'b01 or 2'b10 changes no output register. It raises rxErr for exactly the next cycle.
- R11: rxLock goes to 1 one cycle after a valid-tag word is accepted directly after a valid word of the other kind.
- R12: Once locked, rxLock stays 1 after one bad word. It falls one cycle after the second consecutive bad word. A bad word has an unknown tag, or the same valid tag as the word before it.
- R13: During reset txValid, rxReady, rxLock, rxErr and all receive outputs are 0. The filter history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vidIn | input | 32 | Four video channels, channel 1 in the low byte |
| vidActive | input | 4 | Per-channel activity flag, 0 forces zeros |
| audIn | input | 4 | Audio lines, line 1 in bit 0 |
| datIn | input | 2 | Data lines, line 1 in bit 0 |
| txWord | output | 22 | Outgoing frame word |
| txValid | output | 1 | txWord is offered |
| txReady | input | 1 | Serializer takes txWord this cycle |
| rxWord | input | 22 | Incoming frame word |
| rxValid | input | 1 | rxWord is offered |
| rxReady | output | 1 | Block takes rxWord this cycle |
| vidOut | output | 32 | Received video channels, channel 1 in the low byte |
| audOut | output | 4 | Received audio lines |
| datOut | output | 2 | Filtered received data lines |
| rxLock | output | 1 | Tag alternation is locked |
| rxErr | output | 1 | One-cycle pulse for a dropped word |

## Verification
Every result lands one clock edge after its cause. A transmit word is loaded on the edge where the previous word is accepted. Each receive register, the filter output, rxLock and rxErr change on the edge that accepts rxWord. The bench drives inputs on falling edges and checks on the next falling edge. Each check therefore sees exactly one register stage after its stimulus. rxErr is checked again one further falling edge later, where it must have dropped back to 0.

// File: rtl/tdmFramePkg.sv
package tdmFramePkg;
  localparam logic [1:0] MARK_ONE = 2'b11;
  localparam logic [1:0] MARK_TWO = 2'b00;
  localparam int NUM_VID = 4;
  localparam int NUM_AUD = 4;
  localparam int NUM_DAT = 2;
  localparam int SIDE_W  = 4;

  typedef struct packed {
    logic txLoad;
    logic txSlotOne;
    logic rxLoadOne;
    logic rxLoadTwo;
  } tdmStrobes_t;
endpackage

// File: rtl/tdmFrameCtrl.sv
module tdmFrameCtrl
  import tdmFramePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        txReady,
  output logic        txValid,
  input  logic        rxValid,
  input  logic [1:0]  rxMarker,
  output logic        rxReady,
  output logic        rxLock,
  output logic        rxErr,
  output tdmStrobes_t strb
);
  logic       txValidQ, txNextOne, rxReadyQ, lockQ, errQ, badSeen;
  logic [1:0] prevKind, kindNow;
  logic       rxAcc, pairGood, pairBad;

  always_comb begin
    if (rxMarker == MARK_ONE)      kindNow = 2'd1;
    else if (rxMarker == MARK_TWO) kindNow = 2'd2;
    else                           kindNow = 2'd0;
    rxAcc    = rxValid && rxReadyQ;
    pairGood = (kindNow != 2'd0) && (prevKind != 2'd0) && (kindNow != prevKind);
    pairBad  = (kindNow == 2'd0) || ((prevKind != 2'd0) && (kindNow == prevKind));
    strb.txLoad    = !txValidQ || txReady;
    strb.txSlotOne = txNextOne;
    strb.rxLoadOne = rxAcc && (kindNow == 2'd1);
    strb.rxLoadTwo = rxAcc && (kindNow == 2'd2);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txValidQ  <= 1'b0;
      txNextOne <= 1'b1;
    end else if (strb.txLoad) begin
      txValidQ  <= 1'b1;
      txNextOne <= ~txNextOne;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReadyQ <= 1'b0;
      lockQ    <= 1'b0;
      errQ     <= 1'b0;
      badSeen  <= 1'b0;
      prevKind <= 2'd0;
    end else begin
      rxReadyQ <= 1'b1;
      errQ     <= rxAcc && (kindNow == 2'd0);
      if (rxAcc) begin
        prevKind <= kindNow;
        if (pairGood) begin
          lockQ   <= 1'b1;
          badSeen <= 1'b0;
        end else if (pairBad) begin
          if (badSeen) lockQ <= 1'b0;
          badSeen <= 1'b1;
        end else begin
          badSeen <= 1'b0;
        end
      end
    end
  end

  assign txValid = txValidQ;
  assign rxReady = rxReadyQ;
  assign rxLock  = lockQ;
  assign rxErr   = errQ;
endmodule

// File: rtl/tdmFrameData.sv
module tdmFrameData
  import tdmFramePkg::*;
#(
  parameter int VID_W = 8,
  localparam int VIDS_W = NUM_VID * VID_W,
  localparam int PAY_W  = 2 * VID_W + SIDE_W,
  localparam int WORD_W = 2 + PAY_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  tdmStrobes_t         strb,
  input  logic [VIDS_W-1:0]   vidIn,
  input  logic [NUM_VID-1:0]  vidActive,
  input  logic [NUM_AUD-1:0]  audIn,
  input  logic [NUM_DAT-1:0]  datIn,
  output logic [WORD_W-1:0]   txWord,
  input  logic [PAY_W-1:0]    rxPayload,
  output logic [VIDS_W-1:0]   vidOut,
  output logic [NUM_AUD-1:0]  audOut,
  output logic [NUM_DAT-1:0]  datOut
);
  logic [VIDS_W-1:0]   vidGated;
  logic [2*VID_W-1:0]  smpVid;
  logic [NUM_DAT-1:0]  smpDat;
  logic [WORD_W-1:0]   txWordQ;
  logic [VIDS_W-1:0]   vidOutQ;
  logic [NUM_AUD-1:0]  audOutQ;

  for (genvar k = 0; k < NUM_VID; k++) begin : gGate
    assign vidGated[k*VID_W +: VID_W] = vidIn[k*VID_W +: VID_W] & {VID_W{vidActive[k]}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txWordQ <= '0;
      smpVid  <= '0;
      smpDat  <= '0;
    end else if (strb.txLoad) begin
      if (strb.txSlotOne) begin
        smpVid  <= vidGated[VIDS_W-1:2*VID_W];
        smpDat  <= datIn;
        txWordQ <= {MARK_ONE, vidGated[0 +: VID_W], vidGated[VID_W +: VID_W], audIn};
      end else begin
        txWordQ <= {MARK_TWO, smpVid[0 +: VID_W], smpVid[VID_W +: VID_W],
                    {(SIDE_W-NUM_DAT){1'b0}}, smpDat};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vidOutQ <= '0;
      audOutQ <= '0;
    end else if (strb.rxLoadOne) begin
      vidOutQ[0 +: VID_W]     <= rxPayload[PAY_W-1 -: VID_W];
      vidOutQ[VID_W +: VID_W] <= rxPayload[SIDE_W +: VID_W];
      audOutQ                 <= rxPayload[NUM_AUD-1:0];
    end else if (strb.rxLoadTwo) begin
      vidOutQ[2*VID_W +: VID_W] <= rxPayload[PAY_W-1 -: VID_W];
      vidOutQ[3*VID_W +: VID_W] <= rxPayload[SIDE_W +: VID_W];
    end
  end

  for (genvar d = 0; d < NUM_DAT; d++) begin : gMaj
    logic [1:0] hist;
    logic       voteQ;
    logic       newBit;
    assign newBit = rxPayload[d];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        hist  <= 2'b00;
        voteQ <= 1'b0;
      end else if (strb.rxLoadTwo) begin
        voteQ <= (newBit & hist[0]) | (newBit & hist[1]) | (hist[0] & hist[1]);
        hist  <= {hist[0], newBit};
      end
    end
    assign datOut[d] = voteQ;
  end

  assign txWord = txWordQ;
  assign vidOut = vidOutQ;
  assign audOut = audOutQ;
endmodule

// File: rtl/tdmFrameCodec.sv
module tdmFrameCodec
  import tdmFramePkg::*;
#(
  parameter int VID_W = 8,
  localparam int VIDS_W = NUM_VID * VID_W,
  localparam int WORD_W = 2 + 2 * VID_W + SIDE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [VIDS_W-1:0]  vidIn,
  input  logic [NUM_VID-1:0] vidActive,
  input  logic [NUM_AUD-1:0] audIn,
  input  logic [NUM_DAT-1:0] datIn,
  output logic [WORD_W-1:0]  txWord,
  output logic               txValid,
  input  logic               txReady,
  input  logic [WORD_W-1:0]  rxWord,
  input  logic               rxValid,
  output logic               rxReady,
  output logic [VIDS_W-1:0]  vidOut,
  output logic [NUM_AUD-1:0] audOut,
  output logic [NUM_DAT-1:0] datOut,
  output logic               rxLock,
  output logic               rxErr
);
  tdmStrobes_t strb;

  tdmFrameCtrl uCtrl (
    .clk(clk), .rstN(rstN), .txReady(txReady), .txValid(txValid),
    .rxValid(rxValid), .rxMarker(rxWord[WORD_W-1 -: 2]), .rxReady(rxReady),
    .rxLock(rxLock), .rxErr(rxErr), .strb(strb)
  );

  tdmFrameData #(.VID_W(VID_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .vidIn(vidIn), .vidActive(vidActive),
    .audIn(audIn), .datIn(datIn), .txWord(txWord), .rxPayload(rxWord[WORD_W-3:0]),
    .vidOut(vidOut), .audOut(audOut), .datOut(datOut)
  );
endmodule

// File: rtl/tdmFrameCodecChk.sv
module tdmFrameCodecChk
  import tdmFramePkg::*;
#(
  parameter int VID_W = 8,
  localparam int VIDS_W = NUM_VID * VID_W,
  localparam int WORD_W = 2 + 2 * VID_W + SIDE_W
) (
  input logic               clk,
  input logic               rstN,
  input logic [WORD_W-1:0]  txWord,
  input logic               txValid,
  input logic               txReady,
  input logic [WORD_W-1:0]  rxWord,
  input logic               rxValid,
  input logic               rxReady,
  input logic [VIDS_W-1:0]  vidOut,
  input logic [NUM_AUD-1:0] audOut,
  input logic [NUM_DAT-1:0] datOut,
  input logic               rxLock,
  input logic               rxErr
);
  logic [1:0] txTag, rxTag;
  logic       rxTake, rxBadTag;
  assign txTag    = txWord[WORD_W-1 -: 2];
  assign rxTag    = rxWord[WORD_W-1 -: 2];
  assign rxTake   = rxValid && rxReady;
  assign rxBadTag = (rxTag != MARK_ONE) && (rxTag != MARK_TWO);

  a_r1_tag_legal: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (txTag == MARK_ONE || txTag == MARK_TWO));

  a_r1_tag_alternates: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> (txTag != $past(txTag)));

  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txWord)));

  a_r10_drop_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (rxTake && rxBadTag) |=> (rxErr && $stable(vidOut) && $stable(audOut) && $stable(datOut)));

  a_r10_err_cause: assert property (@(posedge clk) disable iff (!rstN)
    rxErr |-> $past(rxTake && rxBadTag));

  a_r7_one_keeps_upper: assert property (@(posedge clk) disable iff (!rstN)
    (rxTake && rxTag == MARK_ONE) |=> ($stable(datOut) && $stable(vidOut[VIDS_W-1:2*VID_W])));

  a_r8_two_keeps_lower: assert property (@(posedge clk) disable iff (!rstN)
    (rxTake && rxTag == MARK_TWO) |=> ($stable(audOut) && $stable(vidOut[2*VID_W-1:0])));

  a_r11_lock_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxLock) |-> $past(rxTake && !rxBadTag));
endmodule

bind tdmFrameCodec tdmFrameCodecChk #(.VID_W(VID_W)) uChk (.*);

// File: tb/tdmFrameCodec_test.sv
module tdmFrameCodec_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] vidIn = '0;
  logic [3:0]  vidActive = '0;
  logic [3:0]  audIn = '0;
  logic [1:0]  datIn = '0;
  logic [21:0] txWord;
  logic        txValid;
  logic        txReady = 1'b1;
  logic [21:0] rxWord = '0;
  logic        rxValid = 1'b0;
  logic        rxReady;
  logic [31:0] vidOut;
  logic [3:0]  audOut;
  logic [1:0]  datOut;
  logic        rxLock;
  logic        rxErr;

  int checks = 0;
  int fails = 0;
  logic done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  logic [31:0] eVid;
  logic [3:0]  eAud;
  logic [1:0]  eDat;
  logic [1:0]  h0, h1;

  always #10 clk = ~clk;

  tdmFrameCodec uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  function automatic logic [31:0] gate(input logic [31:0] v, input logic [3:0] a);
    logic [31:0] g;
    for (int k = 0; k < 4; k++) g[k*8 +: 8] = a[k] ? v[k*8 +: 8] : 8'h00;
    return g;
  endfunction

  function automatic logic [21:0] wordOne(input logic [31:0] v, input logic [3:0] a, input logic [3:0] au);
    logic [31:0] g;
    g = gate(v, a);
    return {2'b11, g[7:0], g[15:8], au};
  endfunction

  function automatic logic [21:0] wordTwo(input logic [31:0] v, input logic [3:0] a, input logic [1:0] d);
    logic [31:0] g;
    g = gate(v, a);
    return {2'b00, g[23:16], g[31:24], 2'b00, d};
  endfunction

  task automatic randInputs();
    logic [31:0] r;
    vidIn = nextRand();
    r = nextRand();
    vidActive = r[11:8];
    audIn = r[15:12];
    datIn = r[17:16];
  endtask

  task automatic doReset();
    @(negedge clk) rstN = 1'b0;
    @(negedge clk);
    @(negedge clk) rstN = 1'b1;
    eVid = '0; eAud = '0; eDat = '0; h0 = '0; h1 = '0;
  endtask

  task automatic sendRx(input logic [21:0] w);
    @(negedge clk) begin rxValid = 1'b1; rxWord = w; end
    @(negedge clk) rxValid = 1'b0;
  endtask

  task automatic rxExpect(input logic [21:0] w);
    if (w[21:20] == 2'b11) begin
      eVid[15:0] = {w[11:4], w[19:12]};
      eAud = w[3:0];
    end else if (w[21:20] == 2'b00) begin
      eVid[31:16] = {w[11:4], w[19:12]};
      for (int d = 0; d < 2; d++) begin
        eDat[d] = (w[d] & h0[d]) | (w[d] & h1[d]) | (h0[d] & h1[d]);
        h1[d] = h0[d];
        h0[d] = w[d];
      end
    end
  endtask

  initial begin
    logic [31:0] sv;
    logic [3:0]  sa, sau;
    logic [1:0]  sd;
    logic [21:0] held, w;
    logic [31:0] r;

    vidIn = 32'hA1B2C3D4; vidActive = 4'hF; audIn = 4'h9; datIn = 2'b10;
    repeat (3) @(negedge clk);
    // R13: reset state
    check("R13 txValid", {31'd0, txValid}, 32'd0);
    check("R13 rxReady", {31'd0, rxReady}, 32'd0);
    check("R13 vidOut", vidOut, 32'd0);
    check("R13 aud/dat/lock/err", {26'd0, audOut, datOut}, 32'd0);
    check("R13 lock/err", {30'd0, rxLock, rxErr}, 32'd0);
    rstN = 1'b1;
    sv = vidIn; sa = vidActive; sau = audIn; sd = datIn;
    @(negedge clk);
    // R1, R2: first word is the first kind
    check("R1 first valid", {31'd0, txValid}, 32'd1);
    check("R2 first word", {10'd0, txWord}, {10'd0, wordOne(sv, sa, sau)});
    randInputs();
    @(negedge clk);
    // R3, R4: second kind built from the earlier sample
    check("R3 R4 second word", {10'd0, txWord}, {10'd0, wordTwo(sv, sa, sd)});

    for (int i = 0; i < 80; i++) begin
      randInputs();
      if (i == 5) vidActive = 4'h0;   // R5 all channels quiet
      sv = vidIn; sa = vidActive; sau = audIn; sd = datIn;
      @(negedge clk);
      check("R2 R5 slot one", {10'd0, txWord}, {10'd0, wordOne(sv, sa, sau)});
      randInputs();
      @(negedge clk);
      check("R3 R4 R5 slot two", {10'd0, txWord}, {10'd0, wordTwo(sv, sa, sd)});
    end

    // R6: stall on a first-kind word
    randInputs();
    sv = vidIn; sa = vidActive; sau = audIn; sd = datIn;
    @(negedge clk);
    held = txWord;
    check("R6 stall entry", {10'd0, held}, {10'd0, wordOne(sv, sa, sau)});
    txReady = 1'b0;
    for (int i = 0; i < 3; i++) begin
      randInputs();
      @(negedge clk);
      check("R6 stall hold", {9'd0, txValid, txWord}, {9'd0, 1'b1, held});
    end
    txReady = 1'b1;
    @(negedge clk);
    check("R6 R4 after stall", {10'd0, txWord}, {10'd0, wordTwo(sv, sa, sd)});

    // Receive sweep: R7 R8 R9 R10
    doReset();
    for (int i = 0; i < 120; i++) begin
      r = nextRand();
      w = r[21:0];
      if (r[25:24] == 2'b00) w[21:20] = 2'b11;
      else if (r[25:24] == 2'b01) w[21:20] = 2'b00;
      else if (r[26]) w[21:20] = 2'b01;
      else w[21:20] = 2'b10;
      sendRx(w);
      rxExpect(w);
      check("R7 R8 R10 vidOut", vidOut, eVid);
      check("R7 R10 audOut", {28'd0, audOut}, {28'd0, eAud});
      check("R9 R10 datOut", {30'd0, datOut}, {30'd0, eDat});
      check("R10 rxErr pulse", {31'd0, rxErr}, {31'd0, (w[21:20] == 2'b01 || w[21:20] == 2'b10)});
    end
    @(negedge clk);
    check("R10 rxErr one cycle", {31'd0, rxErr}, 32'd0);

    // R9 explicit pattern on line 1: 1,0,1 -> outputs 0,0,1
    doReset();
    sendRx({2'b00, 16'h0000, 4'b0001});
    check("R9 first high", {30'd0, datOut}, 32'd0);
    sendRx({2'b00, 16'h0000, 4'b0000});
    check("R9 then low", {30'd0, datOut}, 32'd0);
    sendRx({2'b00, 16'h0000, 4'b0001});
    check("R9 two of three", {30'd0, datOut}, 32'd1);

    // R11 R12 lock sequence
    doReset();
    sendRx({2'b11, 20'h12345});
    check("R11 one word no lock", {31'd0, rxLock}, 32'd0);
    sendRx({2'b00, 20'h00000});
    check("R11 lock on pair", {31'd0, rxLock}, 32'd1);
    sendRx({2'b01, 20'h00000});
    check("R12 one bad keeps", {31'd0, rxLock}, 32'd1);
    sendRx({2'b10, 20'h00000});
    check("R12 two bad drops", {31'd0, rxLock}, 32'd0);
    sendRx({2'b11, 20'h00000});
    check("R11 after invalid no lock", {31'd0, rxLock}, 32'd0);
    sendRx({2'b11, 20'h00000});
    check("R11 repeat no lock", {31'd0, rxLock}, 32'd0);
    sendRx({2'b00, 20'h00000});
    check("R11 relock", {31'd0, rxLock}, 32'd1);
    sendRx({2'b00, 20'h00000});
    check("R12 repeat once keeps", {31'd0, rxLock}, 32'd1);
    sendRx({2'b00, 20'h00000});
    check("R12 repeat twice drops", {31'd0, rxLock}, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule